// File: doc/BRIEF.md
# Flash command state machine

This block is the command front end of a parallel NOR flash that speaks the classic write-command protocol. Data and command writes share one synchronous bus. A write cycle is taken as a command code or as that command's argument, depending on the active command and on how many cycles of it have already gone by. A small internal word array, split into equal sectors, stands in for the flash cells. The block holds an 8-bit status register, a pair of identification words and a small query table.

A host uses the block the way it would use a real part. It writes a command code and then reads. Depending on the command, a read returns array words, the status register, an identification word or a query byte. Single-word program, sector erase and buffered multi-word write all complete in zero time and set the ready bit at once. A read-only strap stops every change to the array and reports an error bit in its place.

Top module: `flash_cmd_if`

## Requirements
- R1: After synchronous active-high reset, rdValid is low, the status register reads 0x00, the active command is array read, and every array word reads 0xFFFF.
- R2: A read (rdEn high, wrEn low) returns rdData with rdValid high one clock later. When rdEn and wrEn are both high in a cycle, only the write is taken and rdValid stays low in the following cycle.
- R3: With no command sequence in progress, writing 0x00, 0xF0 or 0xFF selects array read. Writing 0x50 clears the status register to 0x00 and selects array read. Any code the block does not recognise is dropped and also selects array read.
- R4: Code 0x10 or 0x40 arms one program. The next write stores its full data word at the word addressed by that write, sets status bit 7 and ends the sequence.
- R5: Code 0x20 immediately fills every word of the sector that contains the written address with 0xFFFF and sets status bit 7. Its second write must be 0xD0, which ends the sequence. A second write of 0xFF, or any other value, selects array read.
- R6: While the read-only strap is high, erase leaves the array unchanged and sets status bit 5. Program and buffered write leave the array unchanged and set status bit 4. Status bit 7 is still set.
- R7: Code 0xE8 sets status bit 7. The next write carries a count N. The N+1 writes after that each store a word at their own address. A final write of 0xD0 ends the sequence with bit 7 set.
- R8: Code 0x60 followed by 0xD0 or 0x01 ends the sequence and sets status bit 7. Any other second write selects array read.
- R9: After 0x10, 0x20, 0x40, 0x50-free status access 0x70, 0x60 or 0xE8 has been written, and until a code that selects another mode, reads return the status register (bit 7 ready, bit 5 erase error, bit 4 program error) in the low byte of rdData.
- R10: After 0x90, a read at word offset 0 (byte address shifted right by log2 of the bus width in bytes) returns {ID0, ID1}, offset 1 returns {ID2, ID3}, and any other offset returns 0.
- R11: After 0x98, a read returns the query byte at its word offset, or 0 when the offset is at or beyond QRY_LEN. Offsets 0x10, 0x11, 0x12 hold 0x51, 0x52, 0x59. Offset 0x13 holds 0x01, 0x27 holds log2 of the array size in bytes, 0x28 holds 0x02, 0x2C holds 0x01 and 0x2D holds the sector count minus one. All other offsets hold 0. Writing 0xFF leaves query mode and any other write keeps it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write cycle strobe |
| rdEn | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | DATA_W | Write data or command code (low byte) |
| roStrap | input | 1 | Read-only strap; blocks array changes |
| rdData | output | DATA_W | Read result |
| rdValid | output | 1 | rdData holds a read result this cycle |

## Verification
The hardest state to reach is the confirm stage of a buffered write while the read-only strap is high. Getting there takes an exact run of writes: the 0xE8 code, a count, exactly N+1 data words, then the confirm code. Both the error bit and the untouched array must then be observed through status and array reads. The bench drives this chain directly, and also reads status partway through the data phase to show that reads do not disturb the cycle count. Random program and readback traffic then runs over an array whose sectors have already been partly erased, so stale words from earlier sequences would show up.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_PROBE     = 8'hF0;
  localparam logic [7:0] CMD_ARRAY     = 8'hFF;
  localparam logic [7:0] CMD_PROG_A    = 8'h10;
  localparam logic [7:0] CMD_PROG_B    = 8'h40;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_ALT = 8'h28;
  localparam logic [7:0] CMD_CLR       = 8'h50;
  localparam logic [7:0] CMD_LOCK      = 8'h60;
  localparam logic [7:0] CMD_STAT      = 8'h70;
  localparam logic [7:0] CMD_ID        = 8'h90;
  localparam logic [7:0] CMD_QRY       = 8'h98;
  localparam logic [7:0] CMD_BUF       = 8'hE8;
  localparam logic [7:0] CODE_CONFIRM  = 8'hD0;
  localparam logic [7:0] CODE_UNLOCK   = 8'h01;

  typedef enum logic [1:0] {CYC_IDLE, CYC_ARG, CYC_DATA, CYC_CONF} cycle_t;
  typedef enum logic [1:0] {SEL_ARRAY, SEL_STATUS, SEL_ID, SEL_QUERY} rdSel_t;

  typedef struct packed {
    logic progWr;
    logic sectErase;
    logic setReady;
    logic setProgErr;
    logic setEraseErr;
    logic clrStatus;
  } dpStrobe_t;

  function automatic logic [7:0] qryByte(input logic [7:0] idx,
                                         input logic [7:0] sizeLog,
                                         input logic [7:0] sectLast);
    case (idx)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return sizeLog;
      8'h28:   return 8'h02;
      8'h2C:   return 8'h01;
      8'h2D:   return sectLast;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       cmdCode,
  input  logic [CNT_W-1:0] countIn,
  input  logic             roStrap,
  output dpStrobe_t        stb,
  output rdSel_t           rdSel
);

  cycle_t           cycle, nxtCycle;
  logic [7:0]       cmd, nxtCmd;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             knownCmd;

  always_comb begin
    unique case (cmd)
      CMD_READ: begin rdSel = SEL_ARRAY; knownCmd = 1'b1; end
      CMD_PROG_A, CMD_PROG_B, CMD_ERASE, CMD_ERASE_ALT, CMD_CLR,
      CMD_LOCK, CMD_STAT, CMD_BUF: begin rdSel = SEL_STATUS; knownCmd = 1'b1; end
      CMD_ID:   begin rdSel = SEL_ID;    knownCmd = 1'b1; end
      CMD_QRY:  begin rdSel = SEL_QUERY; knownCmd = 1'b1; end
      default:  begin rdSel = SEL_ARRAY; knownCmd = 1'b0; end
    endcase
  end

  always_comb begin
    nxtCycle = cycle;
    nxtCmd   = cmd;
    nxtCnt   = cnt;
    stb      = '0;
    if (wrEn) begin
      unique case (cycle)
        CYC_IDLE: begin
          case (cmdCode)
            CMD_READ, CMD_PROBE, CMD_ARRAY: nxtCmd = CMD_READ;
            CMD_CLR: begin
              stb.clrStatus = 1'b1;
              nxtCmd        = CMD_READ;
            end
            CMD_PROG_A, CMD_PROG_B, CMD_LOCK, CMD_QRY: begin
              nxtCmd   = cmdCode;
              nxtCycle = CYC_ARG;
            end
            CMD_ERASE: begin
              if (roStrap) stb.setEraseErr = 1'b1;
              else         stb.sectErase   = 1'b1;
              stb.setReady = 1'b1;
              nxtCmd       = cmdCode;
              nxtCycle     = CYC_ARG;
            end
            CMD_STAT, CMD_ID: nxtCmd = cmdCode;
            CMD_BUF: begin
              stb.setReady = 1'b1;
              nxtCmd       = cmdCode;
              nxtCycle     = CYC_ARG;
            end
            default: nxtCmd = CMD_READ;
          endcase
        end
        CYC_ARG: begin
          case (cmd)
            CMD_PROG_A, CMD_PROG_B: begin
              if (roStrap) stb.setProgErr = 1'b1;
              else         stb.progWr     = 1'b1;
              stb.setReady = 1'b1;
              nxtCycle     = CYC_IDLE;
            end
            CMD_ERASE, CMD_ERASE_ALT: begin
              nxtCycle = CYC_IDLE;
              if (cmdCode == CODE_CONFIRM) stb.setReady = 1'b1;
              else                         nxtCmd       = CMD_READ;
            end
            CMD_BUF: begin
              nxtCnt   = countIn;
              nxtCycle = CYC_DATA;
            end
            CMD_LOCK: begin
              nxtCycle = CYC_IDLE;
              if (cmdCode == CODE_CONFIRM || cmdCode == CODE_UNLOCK) stb.setReady = 1'b1;
              else                                                   nxtCmd       = CMD_READ;
            end
            CMD_QRY: begin
              if (cmdCode == CMD_ARRAY) begin
                nxtCycle = CYC_IDLE;
                nxtCmd   = CMD_READ;
              end
            end
            default: begin
              nxtCycle = CYC_IDLE;
              nxtCmd   = CMD_READ;
            end
          endcase
        end
        CYC_DATA: begin
          if (cmd == CMD_BUF) begin
            if (roStrap) stb.setProgErr = 1'b1;
            else         stb.progWr     = 1'b1;
            stb.setReady = 1'b1;
            if (cnt == '0) nxtCycle = CYC_CONF;
            nxtCnt = cnt - 1'b1;
          end else begin
            nxtCycle = CYC_IDLE;
            nxtCmd   = CMD_READ;
          end
        end
        CYC_CONF: begin
          nxtCycle = CYC_IDLE;
          if (cmd == CMD_BUF && cmdCode == CODE_CONFIRM) stb.setReady = 1'b1;
          else                                           nxtCmd       = CMD_READ;
        end
        default: begin
          nxtCycle = CYC_IDLE;
          nxtCmd   = CMD_READ;
        end
      endcase
    end else if (rdEn && !knownCmd) begin
      nxtCycle = CYC_IDLE;
      nxtCmd   = CMD_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle <= CYC_IDLE;
      cmd   <= CMD_READ;
      cnt   <= '0;
    end else begin
      cycle <= nxtCycle;
      cmd   <= nxtCmd;
      cnt   <= nxtCnt;
    end
  end

  // R7: the data and confirm stages only exist under a buffered write
  a_r7_buf_phase: assert property (@(posedge clk) disable iff (rst)
    (cycle == CYC_DATA || cycle == CYC_CONF) |-> cmd == CMD_BUF);

  // R3: 0xFF with no sequence open lands in array read
  a_r3_array_code: assert property (@(posedge clk) disable iff (rst)
    (wrEn && cycle == CYC_IDLE && cmdCode == CMD_ARRAY) |=> (cmd == CMD_READ && cycle == CYC_IDLE));

  // R2: a bus with no access leaves the command state alone
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !rdEn) |=> ($stable(cmd) && $stable(cycle)));

endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_SECT   = 4,
  parameter int SECT_WORDS = 16,
  parameter int QRY_LEN    = 48,
  parameter logic [7:0] ID0 = 8'h89,
  parameter logic [7:0] ID1 = 8'h18,
  parameter logic [7:0] ID2 = 8'h00,
  parameter logic [7:0] ID3 = 8'h17,
  localparam int BYTES   = DATA_W / 8,
  localparam int BSH     = $clog2(BYTES),
  localparam int WORDS   = NUM_SECT * SECT_WORDS,
  localparam int WAW     = $clog2(WORDS),
  localparam int ADDR_W  = WAW + BSH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              roStrap,
  input  dpStrobe_t         stb,
  input  rdSel_t            rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int SECT_SH    = $clog2(SECT_WORDS);
  localparam int SECT_IDX_W = WAW - SECT_SH;
  localparam logic [7:0] SIZE_LOG  = 8'(ADDR_W);
  localparam logic [7:0] SECT_LAST = 8'(NUM_SECT - 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  eraseHit, progHit;
  logic [WAW-1:0]    wordIdx;
  logic [7:0]        status;
  logic [DATA_W-1:0] rdMux;
  logic              rdTake;

  assign wordIdx = addr[ADDR_W-1:BSH];
  assign rdTake  = rdEn && !wrEn;

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      eraseHit[w] = stb.sectErase &&
                    (wordIdx[WAW-1:SECT_SH] == SECT_IDX_W'(w >> SECT_SH));
      progHit[w]  = stb.progWr && (wordIdx == WAW'(w));
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (rst)              mem[w] <= '1;
      else if (eraseHit[w]) mem[w] <= '1;
      else if (progHit[w])  mem[w] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                status <= 8'h00;
    else if (stb.clrStatus) status <= 8'h00;
    else status <= status | {stb.setReady, 1'b0, stb.setEraseErr, stb.setProgErr, 4'h0};
  end

  always_comb begin
    unique case (rdSel)
      SEL_ARRAY:  rdMux = mem[wordIdx];
      SEL_STATUS: rdMux = DATA_W'(status);
      SEL_ID: begin
        if (wordIdx == WAW'(0))      rdMux = DATA_W'({ID0, ID1});
        else if (wordIdx == WAW'(1)) rdMux = DATA_W'({ID2, ID3});
        else                         rdMux = '0;
      end
      SEL_QUERY: begin
        if (int'(wordIdx) >= QRY_LEN) rdMux = '0;
        else rdMux = DATA_W'(qryByte(8'(wordIdx), SIZE_LOG, SECT_LAST));
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdTake;
      if (rdTake) rdData <= rdMux;
    end
  end

  // R6: with the strap high the control never asks for an array change
  a_r6_ro_no_change: assert property (@(posedge clk) disable iff (rst)
    roStrap |-> (!stb.progWr && !stb.sectErase));

  // R9: at most one array or status-clearing action per cycle
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.progWr, stb.sectErase, stb.clrStatus}));

  // R3: clear command empties the status register
  a_r3_status_clear: assert property (@(posedge clk) disable iff (rst)
    stb.clrStatus |=> status == 8'h00);

  // R4: completion sets the ready bit
  a_r4_ready_set: assert property (@(posedge clk) disable iff (rst)
    stb.setReady |=> status[7]);

  // R2: a write cycle never produces read data
  a_r2_write_wins: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !rdValid);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_SECT   = 4,
  parameter int SECT_WORDS = 16,
  parameter int QRY_LEN    = 48,
  parameter logic [7:0] ID0 = 8'h89,
  parameter logic [7:0] ID1 = 8'h18,
  parameter logic [7:0] ID2 = 8'h00,
  parameter logic [7:0] ID3 = 8'h17,
  localparam int BYTES  = DATA_W / 8,
  localparam int BSH    = $clog2(BYTES),
  localparam int WORDS  = NUM_SECT * SECT_WORDS,
  localparam int WAW    = $clog2(WORDS),
  localparam int ADDR_W = WAW + BSH,
  localparam int CNT_W  = WAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              roStrap,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  dpStrobe_t stb;
  rdSel_t    rdSel;

  flash_cmd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .cmdCode (wrData[7:0]),
    .countIn (wrData[CNT_W-1:0]),
    .roStrap (roStrap),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  flash_datapath #(
    .DATA_W(DATA_W), .NUM_SECT(NUM_SECT), .SECT_WORDS(SECT_WORDS), .QRY_LEN(QRY_LEN),
    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .roStrap (roStrap),
    .stb     (stb),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: tb/sim_flash_cmd_if.sv
`timescale 1ns/1ps
module sim_flash_cmd_if;

  localparam logic [7:0] I0 = 8'h89, I1 = 8'h18, I2 = 8'h00, I3 = 8'h17;

  logic        clk = 1'b0, rst = 1'b1, wrEn = 1'b0, rdEn = 1'b0, roStrap = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdValid;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.DATA_W(16), .NUM_SECT(4), .SECT_WORDS(16), .QRY_LEN(48),
                 .ID0(I0), .ID1(I1), .ID2(I2), .ID3(I3)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .roStrap(roStrap), .rdData(rdData), .rdValid(rdValid));

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [15:0] model [64];

  function automatic logic [15:0] expQry(input int idx);
    if (idx >= 48) return 16'h0;
    case (idx)
      'h10: return 16'h51;
      'h11: return 16'h52;
      'h12: return 16'h59;
      'h13: return 16'h01;
      'h27: return 16'd7;
      'h28: return 16'h02;
      'h2C: return 16'h01;
      'h2D: return 16'd3;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] expStatus(input bit rdy, input bit eErr, input bit pErr);
    return {8'h00, rdy, 1'b0, eErr, pErr, 4'h0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input int w, input logic [15:0] d);
    @(negedge clk);
    addr = 7'(w * 2); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input int w, input logic [15:0] exp);
    @(negedge clk);
    addr = 7'(w * 2); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk({tag, " valid"}, {15'h0, rdValid}, 16'h1);
    chk(tag, rdData, exp);
  endtask

  task automatic prog(input int w, input logic [15:0] d, input logic [7:0] code);
    busWr(w, {8'h00, code});
    busWr(w, d);
    busWr(0, 16'hFF);
    model[w] = d;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk("R1 rdValid after reset", {15'h0, rdValid}, 16'h0);
    rdChk("R1 erased array after reset", 10, 16'hFFFF);
    busWr(0, 16'h70);
    rdChk("R1 status after reset", 0, 16'h0000);
    busWr(0, 16'hFF);

    // R2: write wins over read in the same cycle
    @(negedge clk);
    addr = 0; wrData = 16'hFF; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R2 collision gives no rdValid", {15'h0, rdValid}, 16'h0);

    // R4 / R9: single program with both codes
    busWr(5, 16'h40);
    busWr(5, 16'h1234);
    model[5] = 16'h1234;
    rdChk("R9 status after program", 0, expStatus(1, 0, 0));
    busWr(0, 16'hFF);
    rdChk("R4 program code 0x40", 5, 16'h1234);
    prog(6, 16'hBEEF, 8'h10);
    rdChk("R4 program code 0x10", 6, 16'hBEEF);

    // R3: clear, unknown codes, read-array aliases
    busWr(0, 16'h70);
    busWr(0, 16'h50);
    rdChk("R3 clear selects array", 5, 16'h1234);
    busWr(0, 16'h70);
    rdChk("R3 status cleared", 0, 16'h0000);
    busWr(0, 16'h33);
    rdChk("R3 unknown code selects array", 5, 16'h1234);
    busWr(0, 16'h70);
    busWr(0, 16'hF0);
    rdChk("R3 code 0xF0 selects array", 6, 16'hBEEF);
    busWr(0, 16'h70);
    busWr(0, 16'h00);
    rdChk("R3 code 0x00 selects array", 6, 16'hBEEF);

    // R5: sector erase
    prog(20, 16'hABCD, 8'h40);
    prog(3, 16'h1111, 8'h40);
    busWr(0, 16'h50);
    busWr(25, 16'h20);
    busWr(25, 16'hD0);
    for (int i = 16; i < 32; i++) model[i] = 16'hFFFF;
    rdChk("R5 status after erase", 0, expStatus(1, 0, 0));
    busWr(0, 16'hFF);
    rdChk("R5 erased word in sector", 20, 16'hFFFF);
    rdChk("R5 erased last word of sector", 31, 16'hFFFF);
    rdChk("R5 other sector kept", 3, 16'h1111);
    prog(40, 16'h5555, 8'h40);
    busWr(40, 16'h20);
    busWr(40, 16'hFF);
    for (int i = 32; i < 48; i++) model[i] = 16'hFFFF;
    rdChk("R5 erase then 0xFF reads array", 40, 16'hFFFF);
    busWr(50, 16'h20);
    busWr(50, 16'h55);
    rdChk("R5 bad second cycle reads array", 3, 16'h1111);

    // R8: lock sequences
    busWr(0, 16'h50);
    busWr(0, 16'h60);
    busWr(0, 16'hD0);
    rdChk("R8 lock confirm status", 0, expStatus(1, 0, 0));
    busWr(0, 16'h50);
    busWr(0, 16'h60);
    busWr(0, 16'h01);
    rdChk("R8 unlock status", 0, expStatus(1, 0, 0));
    busWr(0, 16'h60);
    busWr(0, 16'h77);
    rdChk("R8 bad second cycle reads array", 5, 16'h1234);

    // R10: identification
    busWr(0, 16'h90);
    rdChk("R10 id offset 0", 0, {I0, I1});
    rdChk("R10 id offset 1", 1, {I2, I3});
    rdChk("R10 id offset 2", 2, 16'h0);
    rdChk("R10 id offset 63", 63, 16'h0);
    busWr(0, 16'hFF);

    // R11: query table
    busWr(0, 16'h98);
    rdChk("R11 query 0x10", 'h10, expQry('h10));
    rdChk("R11 query 0x11", 'h11, expQry('h11));
    rdChk("R11 query 0x12", 'h12, expQry('h12));
    rdChk("R11 query size", 'h27, expQry('h27));
    rdChk("R11 query sectors", 'h2D, expQry('h2D));
    rdChk("R11 query regions", 'h2C, expQry('h2C));
    rdChk("R11 query unlisted", 'h14, expQry('h14));
    rdChk("R11 query beyond length", 'h30, expQry('h30));
    busWr(0, 16'h00);
    rdChk("R11 other write keeps query", 'h10, expQry('h10));
    busWr(0, 16'hFF);
    rdChk("R11 0xFF leaves query", 'h10, model['h10]);

    // R7: buffered write of three words
    busWr(0, 16'h50);
    busWr(8, 16'hE8);
    busWr(8, 16'd2);
    busWr(8, 16'hA001);
    rdChk("R7 status during data phase", 0, expStatus(1, 0, 0));
    busWr(9, 16'hA002);
    busWr(10, 16'hA003);
    busWr(8, 16'hD0);
    model[8] = 16'hA001; model[9] = 16'hA002; model[10] = 16'hA003;
    rdChk("R7 status after confirm", 0, expStatus(1, 0, 0));
    busWr(0, 16'hFF);
    rdChk("R7 first word", 8, 16'hA001);
    rdChk("R7 middle word", 9, 16'hA002);
    rdChk("R7 last word", 10, 16'hA003);

    // R6: read-only strap
    roStrap = 1'b1;
    busWr(0, 16'h50);
    busWr(5, 16'h40);
    busWr(5, 16'h0000);
    rdChk("R6 program error status", 0, expStatus(1, 0, 1));
    busWr(0, 16'hFF);
    rdChk("R6 program left word", 5, 16'h1234);
    busWr(0, 16'h50);
    busWr(5, 16'h20);
    busWr(5, 16'hD0);
    rdChk("R6 erase error status", 0, expStatus(1, 1, 0));
    busWr(0, 16'hFF);
    rdChk("R6 erase left word", 5, 16'h1234);
    busWr(0, 16'h50);
    busWr(8, 16'hE8);
    busWr(8, 16'd0);
    busWr(8, 16'h0000);
    busWr(8, 16'hD0);
    rdChk("R6 buffered error status", 0, expStatus(1, 0, 1));
    busWr(0, 16'hFF);
    rdChk("R6 buffered left word", 8, 16'hA001);
    roStrap = 1'b0;

    // R4: random program and readback
    void'($urandom(32'd2024));
    for (int n = 0; n < 150; n++) begin
      int w, r;
      logic [15:0] d;
      w = int'($urandom_range(0, 63));
      r = int'($urandom_range(0, 63));
      d = 16'($urandom);
      prog(w, d, ($urandom_range(0, 1) == 0) ? 8'h10 : 8'h40);
      rdChk("R4 random readback", r, model[r]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule